// File: doc/BRIEF.md
# Receive-side lane control state machine

This block tracks the low-power control state of one bidirectional serial lane on the receiving end of a link. It watches the synchronised single-ended line levels, decides when the lane is idle and ready (stop state), follows the lane into and out of the ultra-low-power state, and keeps the current lane direction across a bus turnaround in either direction. Line-level sequences that break the expected order raise a control error flag, which stays up until the next transaction starts.

The line input carries the positive wire in bit 1 and the negative wire in bit 0, so 2'b11 is the idle level LP-11, 2'b10 is LP-10 (also called Mark-1), 2'b01 is LP-01 and 2'b00 is LP-00. The escape byte decoder is a separate block: it reports a recognised ultra-low-power command through a one-cycle event input. The three timing windows (initialisation, wakeup, turnaround settle) are parameters counted in clock cycles. Each window restarts whenever the line leaves the level being timed.

Top module: `lane_ctrl`

## Requirements
- R1: After reset or re-enable, `stop_o` stays 0 until the line has read 2'b11 for `T_INIT` consecutive clock edges. It rises right after the edge that completes the window. Any other level restarts the count. Out of reset the outputs are `stop_o`=0, `ulps_o`=0, `ulps_n_o`=1, `dir_o`=1, `ctrl_err_o`=0 and `force_clash_o`=0.
- R2: While `en_i` is 0, the outputs hold the values of R1 without waiting for a clock: `stop_o`=0, `ulps_o`=0, `ulps_n_o`=1, `dir_o`=1, `ctrl_err_o`=0, `force_clash_o`=0. All other inputs have no effect. Raising `en_i` starts the initialisation window of R1 again.
- R3: While `force_rx_i` is high, the lane leaves any state on the next edge. It sets `dir_o`=1, `stop_o`=0 and clears both ULPS indicators. Once `force_rx_i` is released, the first edge that sees 2'b11 sets `stop_o`.
- R4: In receive stop state, the sequence 2'b10, 2'b00, 2'b01 enters escape mode. An `esc_ulps_i` pulse there raises `ulps_o` on the next edge while `ulps_n_o` is still 1. `ulps_n_o` falls one edge later.
- R5: In the ultra-low-power state, the first 2'b10 edge raises `ulps_n_o` and leaves `ulps_o` at 1. `ulps_o` clears on a 2'b11 edge only if the line read 2'b10 on at least `T_WAKE` more consecutive edges after that first one. An earlier 2'b11 clears `ulps_o` and raises `ctrl_err_o`. Both cases reach stop state.
- R6: `turn_i` has no effect while `dir_o` is 1. While `dir_o` is 0, only a 0-to-1 change of `turn_i` seen while `stop_o` is 1 starts a turnaround, and it drops `stop_o`. A level that was already high when stop state began does nothing.
- R7: After a turnaround starts with `dir_o`=0, `dir_o` becomes 1 only on a 2'b11 edge that follows a 2'b10 edge. `stop_o` rises on the same edge.
- R8: In receive stop state, the sequence 2'b10, 2'b00, 2'b10, 2'b00 followed by 2'b00 on `T_TASURE` more edges sets `dir_o` to 0. A later 2'b11 sets `stop_o`.
- R9: An illegal move raises `ctrl_err_o`. The illegal moves are: 2'b00 straight after stop state, 2'b11 straight after 2'b10 or after 2'b10-2'b00, and leaving 2'b00 before the turnaround settle window ends. `ctrl_err_o` stays high, including through stop state, until the line leaves stop state or a turnaround starts.
- R10: If `force_rx_i` and `force_txstop_i` are high together, the receive force wins (`dir_o`=1) and `force_clash_o` rises and stays high until reset or disable. `force_txstop_i` alone sets `dir_o`=0 and `stop_o`=1 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Lane enable; low forces inactive outputs |
| line_i | input | 2 | Synchronised line levels {positive, negative} |
| force_rx_i | input | 1 | Force receive mode and wait for stop |
| force_txstop_i | input | 1 | Force transmit direction and stop state |
| turn_i | input | 1 | Turnaround request level |
| esc_ulps_i | input | 1 | One-cycle event: ULPS escape command decoded |
| stop_o | output | 1 | Lane is in stop state |
| ulps_o | output | 1 | Ultra-low-power state flag (active high) |
| ulps_n_o | output | 1 | Ultra-low-power active indicator (active low) |
| dir_o | output | 1 | Direction: 1 receive, 0 transmit |
| ctrl_err_o | output | 1 | Control sequence error, held to next transaction |
| force_clash_o | output | 1 | Sticky: both force inputs seen together |

## Verification
The bench builds the block with `T_INIT`=8, `T_WAKE`=5 and `T_TASURE`=4. These short windows let every break position inside the initialisation window and every early-wakeup length up to and past the wakeup limit be swept in full. Each sweep point expects exactly the edge that the cycle counts predict. The short turnaround window puts both directions of turnaround, the settle-window error and the edge-only turn request within a short run. The forced transitions and the disable behaviour are also checked from several starting states.

// File: rtl/lane_ctrl_pkg.sv
package lane_ctrl_pkg;

  localparam logic [1:0] LP_00 = 2'b00;
  localparam logic [1:0] LP_01 = 2'b01;
  localparam logic [1:0] LP_10 = 2'b10;
  localparam logic [1:0] LP_11 = 2'b11;

  typedef enum logic [4:0] {
    ST_INIT, ST_STOP, ST_HS, ST_LPRQ, ST_BRIDGE, ST_ESC, ST_ULPS_ENT,
    ST_ULPS, ST_WAKE, ST_WAKE_OK, ST_TA_REQ, ST_TA_SURE, ST_WAIT_STOP,
    ST_TX_LP00, ST_TX_STOP, ST_TX_TURN, ST_TX_MARK
  } lane_st_t;

  typedef enum logic [1:0] {TM_INIT, TM_WAKE, TM_TASURE} tmr_sel_t;

  typedef struct packed {
    logic stop;
    logic ulps;
    logic ulps_n;
    logic dir;
    logic err;
    logic clash;
  } lane_out_t;

  localparam lane_out_t OUT_IDLE = '{stop: 1'b0, ulps: 1'b0, ulps_n: 1'b1,
                                     dir: 1'b1, err: 1'b0, clash: 1'b0};

endpackage

// File: rtl/lane_ctrl_timer.sv
module lane_ctrl_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last   = (limit_i == '0) ? '0 : limit_i - 1'b1;
  assign done_o = run_i && (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (rst || !run_i) cnt_q <= '0;
    else if (!done_o)  cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/lane_ctrl_fsm.sv
module lane_ctrl_fsm
  import lane_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      en_i,
  input  logic [1:0] line_i,
  input  logic      force_rx_i,
  input  logic      force_tx_i,
  input  logic      turn_i,
  input  logic      esc_ulps_i,
  input  logic      tmr_done_i,
  output logic      tmr_run_o,
  output tmr_sel_t  tmr_sel_o,
  output lane_out_t q_o
);
  lane_st_t  st_q, st_n;
  lane_out_t q_q, q_n;
  logic      turn_q;
  logic      turn_rise;
  logic      illegal, start;

  assign turn_rise = turn_i && !turn_q;

  always_comb begin
    tmr_run_o = 1'b0;
    tmr_sel_o = TM_INIT;
    case (st_q)
      ST_INIT:    begin tmr_run_o = (line_i == LP_11); tmr_sel_o = TM_INIT;   end
      ST_WAKE:    begin tmr_run_o = (line_i == LP_10); tmr_sel_o = TM_WAKE;   end
      ST_TA_SURE: begin tmr_run_o = (line_i == LP_00); tmr_sel_o = TM_TASURE; end
      default:    ;
    endcase
  end

  always_comb begin
    st_n    = st_q;
    q_n     = q_q;
    illegal = 1'b0;
    start   = 1'b0;
    case (st_q)
      ST_INIT:      if (tmr_done_i) st_n = ST_STOP;
      ST_STOP: begin
        if (line_i != LP_11) start = 1'b1;
        case (line_i)
          LP_10:   st_n = ST_LPRQ;
          LP_01:   st_n = ST_HS;
          LP_00:   begin st_n = ST_WAIT_STOP; illegal = 1'b1; end
          default: ;
        endcase
      end
      ST_HS:        if (line_i == LP_11) st_n = ST_STOP;
      ST_LPRQ:
        case (line_i)
          LP_00:   st_n = ST_BRIDGE;
          LP_11:   begin st_n = ST_STOP; illegal = 1'b1; end
          LP_01:   begin st_n = ST_WAIT_STOP; illegal = 1'b1; end
          default: ;
        endcase
      ST_BRIDGE:
        case (line_i)
          LP_01:   st_n = ST_ESC;
          LP_10:   st_n = ST_TA_REQ;
          LP_11:   begin st_n = ST_STOP; illegal = 1'b1; end
          default: ;
        endcase
      ST_ESC:
        if (esc_ulps_i) begin st_n = ST_ULPS_ENT; q_n.ulps = 1'b1; end
        else if (line_i == LP_11) st_n = ST_STOP;
      ST_ULPS_ENT:  begin st_n = ST_ULPS; q_n.ulps_n = 1'b0; end
      ST_ULPS:
        if (line_i == LP_10) begin st_n = ST_WAKE; q_n.ulps_n = 1'b1; end
        else if (line_i != LP_00) illegal = 1'b1;
      ST_WAKE:
        if (tmr_done_i) st_n = ST_WAKE_OK;
        else if (line_i == LP_11) begin
          st_n = ST_STOP; q_n.ulps = 1'b0; illegal = 1'b1;
        end
      ST_WAKE_OK:
        if (line_i == LP_11) begin st_n = ST_STOP; q_n.ulps = 1'b0; end
      ST_TA_REQ:
        case (line_i)
          LP_00:   st_n = ST_TA_SURE;
          LP_11:   begin st_n = ST_STOP; illegal = 1'b1; end
          LP_01:   begin st_n = ST_WAIT_STOP; illegal = 1'b1; end
          default: ;
        endcase
      ST_TA_SURE:
        if (tmr_done_i) begin st_n = ST_TX_LP00; q_n.dir = 1'b0; end
        else if (line_i != LP_00) begin st_n = ST_WAIT_STOP; illegal = 1'b1; end
      ST_WAIT_STOP: if (line_i == LP_11) st_n = ST_STOP;
      ST_TX_LP00:   if (line_i == LP_11) st_n = ST_TX_STOP;
      ST_TX_STOP:   if (turn_rise) begin st_n = ST_TX_TURN; start = 1'b1; end
      ST_TX_TURN:   if (line_i == LP_10) st_n = ST_TX_MARK;
      ST_TX_MARK:
        case (line_i)
          LP_11:   begin st_n = ST_STOP; q_n.dir = 1'b1; end
          LP_00:   st_n = ST_TX_TURN;
          LP_01:   illegal = 1'b1;
          default: ;
        endcase
      default: st_n = ST_INIT;
    endcase

    if (start)   q_n.err = 1'b0;
    if (illegal) q_n.err = 1'b1;

    if (force_rx_i) begin
      st_n = ST_WAIT_STOP; q_n.dir = 1'b1; q_n.ulps = 1'b0; q_n.ulps_n = 1'b1;
      if (force_tx_i) q_n.clash = 1'b1;
    end else if (force_tx_i) begin
      st_n = ST_TX_STOP; q_n.dir = 1'b0; q_n.ulps = 1'b0; q_n.ulps_n = 1'b1;
    end

    q_n.stop = (st_n == ST_STOP) || (st_n == ST_TX_STOP);
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      st_q   <= ST_INIT;
      q_q    <= OUT_IDLE;
      turn_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      q_q    <= q_n;
      turn_q <= turn_i;
    end
  end

  assign q_o = q_q;

  AST_STOP_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst || !en_i)
    ($rose(q_q.stop) && q_q.dir) |-> ($past(line_i) == LP_11)); // R1
  AST_FORCE_RX_WINS: assert property (@(posedge clk) disable iff (rst || !en_i)
    force_rx_i |=> (q_q.dir && !q_q.stop && !q_q.ulps)); // R3
  AST_ULPS_ENTRY_ORDER: assert property (@(posedge clk) disable iff (rst || !en_i)
    $fell(q_q.ulps_n) |-> (q_q.ulps && $past(q_q.ulps))); // R4
  AST_ULPS_EXIT_MARK: assert property (@(posedge clk) disable iff (rst || !en_i)
    ($rose(q_q.ulps_n) && q_q.ulps) |-> ($past(line_i) == LP_10)); // R5
  AST_DIR_TO_RX: assert property (@(posedge clk) disable iff (rst || !en_i)
    $rose(q_q.dir) |-> ($past(line_i) == LP_11 || $past(force_rx_i))); // R7
  AST_DIR_TO_TX: assert property (@(posedge clk) disable iff (rst || !en_i)
    $fell(q_q.dir) |-> ($past(line_i) == LP_00 || $past(force_tx_i))); // R8

endmodule

// File: rtl/lane_ctrl_outgate.sv
module lane_ctrl_outgate
  import lane_ctrl_pkg::*;
(
  input  logic      en_i,
  input  lane_out_t q_i,
  output lane_out_t q_o
);
  assign q_o = en_i ? q_i : OUT_IDLE;
endmodule

// File: rtl/lane_ctrl.sv
module lane_ctrl
  import lane_ctrl_pkg::*;
#(
  parameter int T_INIT   = 2000,
  parameter int T_WAKE   = 1000,
  parameter int T_TASURE = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic [1:0] line_i,
  input  logic       force_rx_i,
  input  logic       force_txstop_i,
  input  logic       turn_i,
  input  logic       esc_ulps_i,
  output logic       stop_o,
  output logic       ulps_o,
  output logic       ulps_n_o,
  output logic       dir_o,
  output logic       ctrl_err_o,
  output logic       force_clash_o
);
  localparam int MAX_A = (T_INIT > T_WAKE) ? T_INIT : T_WAKE;
  localparam int MAX_T = (MAX_A > T_TASURE) ? MAX_A : T_TASURE;
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic             tmr_run, tmr_done;
  tmr_sel_t         tmr_sel;
  logic [CNT_W-1:0] tmr_limit;
  lane_out_t        q_raw, q_out;

  always_comb begin
    case (tmr_sel)
      TM_WAKE:   tmr_limit = CNT_W'(T_WAKE);
      TM_TASURE: tmr_limit = CNT_W'(T_TASURE);
      default:   tmr_limit = CNT_W'(T_INIT);
    endcase
  end

  lane_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst     (rst || !en_i),
    .run_i   (tmr_run),
    .limit_i (tmr_limit),
    .done_o  (tmr_done)
  );

  lane_ctrl_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_i),
    .line_i     (line_i),
    .force_rx_i (force_rx_i),
    .force_tx_i (force_txstop_i),
    .turn_i     (turn_i),
    .esc_ulps_i (esc_ulps_i),
    .tmr_done_i (tmr_done),
    .tmr_run_o  (tmr_run),
    .tmr_sel_o  (tmr_sel),
    .q_o        (q_raw)
  );

  lane_ctrl_outgate u_gate (
    .en_i (en_i),
    .q_i  (q_raw),
    .q_o  (q_out)
  );

  assign stop_o        = q_out.stop;
  assign ulps_o        = q_out.ulps;
  assign ulps_n_o      = q_out.ulps_n;
  assign dir_o         = q_out.dir;
  assign ctrl_err_o    = q_out.err;
  assign force_clash_o = q_out.clash;

endmodule

// File: tb/lane_ctrl_bench.sv
module lane_ctrl_bench;
  localparam int T_INIT   = 8;
  localparam int T_WAKE   = 5;
  localparam int T_TASURE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b1;
  logic [1:0] line = 2'b11;
  logic frx = 1'b0, ftx = 1'b0, turn = 1'b0, escu = 1'b0;
  logic stop, ulps, ulps_n, dir, err, clash;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  lane_ctrl #(.T_INIT(T_INIT), .T_WAKE(T_WAKE), .T_TASURE(T_TASURE)) u_lane_ctrl (
    .clk(clk), .rst(rst), .en_i(en), .line_i(line), .force_rx_i(frx),
    .force_txstop_i(ftx), .turn_i(turn), .esc_ulps_i(escu),
    .stop_o(stop), .ulps_o(ulps), .ulps_n_o(ulps_n), .dir_o(dir),
    .ctrl_err_o(err), .force_clash_o(clash)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drv(input logic [1:0] l, input int n);
    line = l;
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic do_reset();
    rst = 1'b1; en = 1'b1; line = 2'b11; frx = 0; ftx = 0; turn = 0; escu = 0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic go_stop();
    do_reset();
    drv(2'b11, T_INIT);
  endtask

  task automatic enter_ulps();
    go_stop();
    drv(2'b10, 1); drv(2'b00, 1); drv(2'b01, 1);
    line = 2'b00; escu = 1'b1;
    @(posedge clk); @(negedge clk);
    escu = 1'b0;
    chk("R4 ulps flag first", ulps, 1);
    chk("R4 ulps_n still high", ulps_n, 1);
    drv(2'b00, 1);
    chk("R4 ulps_n low after flag", ulps_n, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 reset stop", stop, 0);
    chk("R1 reset ulps", ulps, 0);
    chk("R1 reset ulps_n", ulps_n, 1);
    chk("R1 reset dir", dir, 1);
    chk("R1 reset err", err, 0);
    chk("R1 reset clash", clash, 0);
    drv(2'b11, T_INIT - 1);
    chk("R1 stop before window", stop, 0);
    drv(2'b11, 1);
    chk("R1 stop at window", stop, 1);

    // R1: every break position inside the initialisation window
    for (int k = 1; k < T_INIT; k++) begin
      do_reset();
      drv(2'b11, k); drv(2'b00, 1);
      drv(2'b11, T_INIT - 1);
      chk("R1 restart early", stop, 0);
      drv(2'b11, 1);
      chk("R1 restart full", stop, 1);
    end

    // R9 illegal moves and hold
    go_stop();
    drv(2'b00, 1);
    chk("R9 err on 11->00", err, 1);
    chk("R9 no stop", stop, 0);
    drv(2'b11, 1);
    chk("R9 err held in stop", err, 1);
    chk("R9 stop back", stop, 1);
    drv(2'b10, 1);
    chk("R9 err cleared at start", err, 0);
    drv(2'b11, 1);
    chk("R9 err on 10->11", err, 1);
    go_stop();
    drv(2'b01, 1); drv(2'b00, 5); drv(2'b11, 1);
    chk("R9 hs burst legal", err, 0);
    chk("R9 hs back to stop", stop, 1);

    // R4/R5 ULPS with exit length sweep
    for (int w = 1; w <= T_WAKE + 1; w++) begin
      enter_ulps();
      drv(2'b00, 2);
      drv(2'b10, 1);
      chk("R5 ulps_n up on mark", ulps_n, 1);
      chk("R5 ulps held on mark", ulps, 1);
      drv(2'b10, w - 1);
      chk("R5 ulps held before idle", ulps, 1);
      drv(2'b11, 1);
      chk("R5 ulps cleared", ulps, 0);
      chk("R5 stop after exit", stop, 1);
      chk("R5 early exit error", err, (w <= T_WAKE) ? 1 : 0);
    end

    // R6 turn ignored in receive
    go_stop();
    turn = 1'b1;
    drv(2'b11, 3);
    chk("R6 turn ignored dir", dir, 1);
    chk("R6 turn ignored stop", stop, 1);
    turn = 1'b0;

    // R8 receive to transmit
    go_stop();
    drv(2'b10, 1); drv(2'b00, 1); drv(2'b10, 1); drv(2'b00, 1);
    drv(2'b00, T_TASURE - 1);
    chk("R8 dir before settle", dir, 1);
    drv(2'b00, 1);
    chk("R8 dir after settle", dir, 0);
    chk("R8 no stop while 00", stop, 0);
    turn = 1'b1;
    drv(2'b00, 1);
    drv(2'b11, 1);
    chk("R8 tx stop", stop, 1);
    drv(2'b11, 2);
    chk("R6 held level no turn", stop, 1);
    turn = 1'b0;
    drv(2'b11, 1);
    turn = 1'b1;
    drv(2'b11, 1);
    chk("R6 rising edge turns", stop, 0);
    turn = 1'b0;
    drv(2'b00, 2);
    chk("R7 dir tx during turn", dir, 0);
    drv(2'b10, 1);
    chk("R7 dir tx after mark", dir, 0);
    drv(2'b11, 1);
    chk("R7 dir rx", dir, 1);
    chk("R7 stop rx", stop, 1);

    // R9 settle window broken
    go_stop();
    drv(2'b10, 1); drv(2'b00, 1); drv(2'b10, 1); drv(2'b00, 1);
    drv(2'b00, 2); drv(2'b10, 1);
    chk("R9 settle break err", err, 1);
    chk("R9 settle break dir", dir, 1);
    chk("R9 settle break stop", stop, 0);

    // R10/R3 forces
    go_stop();
    ftx = 1'b1; drv(2'b11, 1); ftx = 1'b0;
    chk("R10 force tx dir", dir, 0);
    chk("R10 force tx stop", stop, 1);
    frx = 1'b1; drv(2'b11, 2);
    chk("R3 force rx dir", dir, 1);
    chk("R3 force rx no stop", stop, 0);
    frx = 1'b0; drv(2'b11, 1);
    chk("R3 stop after release", stop, 1);
    chk("R10 no clash", clash, 0);
    enter_ulps();
    frx = 1'b1; drv(2'b00, 1); frx = 1'b0;
    chk("R3 force clears ulps", ulps, 0);
    chk("R3 force ulps_n", ulps_n, 1);
    go_stop();
    ftx = 1'b1; frx = 1'b1; drv(2'b11, 1); ftx = 1'b0; frx = 1'b0;
    chk("R10 rx wins", dir, 1);
    chk("R10 clash set", clash, 1);
    drv(2'b11, 3);
    chk("R10 clash sticky", clash, 1);

    // R2 enable gating
    en = 1'b0; #1;
    chk("R2 disabled stop", stop, 0);
    chk("R2 disabled clash", clash, 0);
    chk("R2 disabled dir", dir, 1);
    chk("R2 disabled ulps_n", ulps_n, 1);
    ftx = 1'b1; drv(2'b00, 3); ftx = 1'b0;
    chk("R2 force ignored dir", dir, 1);
    chk("R2 err ignored", err, 0);
    line = 2'b11; en = 1'b1;
    drv(2'b11, T_INIT - 1);
    chk("R2 init again", stop, 0);
    drv(2'b11, 1);
    chk("R2 stop after init", stop, 1);
    chk("R2 clash cleared", clash, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule